// File: doc/BRIEF.md
# Register-Driven Packet Mailbox

This block lets a host that only issues 32-bit register reads and writes exchange 64-bit packet beats with a streaming packet engine. To send, the host loads the low and high halves of a beat into two staging registers and then writes a control word whose two low bits tag the beat as packet start, packet end, both or neither. That control write commits the beat to an eight-entry transmit queue, which drains onto a valid/ready stream carrying start and end markers.

On the return path, completion beats offered on a valid/ready input stream are captured into an eight-entry receive queue. The host polls a status word to learn whether a beat is waiting and whether it closes a completion, then reads the low half and the high half. Reading the high half retires the entry. There is no interrupt; polling is the only notification.

Read data is returned one clock after the read strobe, with a matching valid pulse.

Top module: `tlpmb_mailbox`

## Requirements
- R1: After reset, tx_valid and tx_ovf are 0, rx_ready is 1, and the status word at offset 0x10 reads 0.
- R2: A write to offset 0x08 pushes one beat whose tx_data[31:0] is the last value written to offset 0x00, tx_data[63:32] the last value written to offset 0x04, tx_sop is bit 0 and tx_eop is bit 1 of the written word; beats leave the stream in the order they were committed.
- R3: The transmit queue holds 8 beats; a commit while it is full is dropped, leaves the queued beats intact, and sets tx_ovf, which stays 1 until reset.
- R4: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data, tx_sop, tx_eop hold their values; a beat leaves only on a cycle with both high.
- R5: The staging registers at 0x00 and 0x04 keep their contents across commits, so a half that does not change need not be rewritten.
- R6: The status word at 0x10 has bit 0 = 1 when the receive queue holds a beat and bit 1 = the end marker of the oldest beat; both are 0 when empty and bits 31:2 always read 0.
- R7: A read of 0x14 returns the low half of the oldest received beat without removing it; a read of 0x18 returns its high half and removes it.
- R8: The receive queue holds 8 beats; rx_ready is 0 while it is full, and beats are returned in arrival order.
- R9: Reads of 0x14 and 0x18 with an empty receive queue return 0 and change nothing.
- R10: Reads of 0x00, 0x04, 0x08 and any unmapped offset return 0; writes to 0x10, 0x14 and 0x18 have no effect.
- R11: reg_rvalid is 1 exactly in the cycle after a cycle with reg_rd high, and reg_rdata carries the addressed value then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| tx_valid | output | 1 | Transmit beat available |
| tx_ready | input | 1 | Sink accepts transmit beat |
| tx_data | output | 64 | Transmit beat data |
| tx_sop | output | 1 | Transmit beat starts a packet |
| tx_eop | output | 1 | Transmit beat ends a packet |
| tx_ovf | output | 1 | Sticky: a commit was dropped on a full queue |
| rx_valid | input | 1 | Receive beat offered |
| rx_ready | output | 1 | Receive queue can take a beat |
| rx_data | input | 64 | Receive beat data |
| rx_sop | input | 1 | Receive beat starts a completion |
| rx_eop | input | 1 | Receive beat ends a completion |

## Verification
The bench fills the transmit queue and commits a ninth beat: a design that overwrote the oldest entry or wrapped its pointer would hand back a wrong first beat, and one without a sticky flag would leave tx_ovf low. It reads the low half of a received beat twice before the high half; a design that retired on the low-half read would return the next beat the second time. It fills the receive queue and offers one more beat, catching a design that accepts into a full queue, and then reads an empty queue, where a stale head or a pointer underflow would show as nonzero data or status. Writes to read-only offsets with a beat queued expose any decode that lets them pop or corrupt the queue.

// File: rtl/tlpmb_pkg.sv
package tlpmb_pkg;
    localparam int REG_W  = 32;
    localparam int BEAT_W = 64;

    localparam int OFS_TX_LO  = 'h00;
    localparam int OFS_TX_HI  = 'h04;
    localparam int OFS_TX_CTL = 'h08;
    localparam int OFS_STATUS = 'h10;
    localparam int OFS_RX_LO  = 'h14;
    localparam int OFS_RX_HI  = 'h18;

    typedef struct packed {
        logic [BEAT_W-1:0] data;
        logic              eop;
        logic              sop;
    } beat_t;

    localparam int ENTRY_W = $bits(beat_t);
endpackage

// File: rtl/tlpmb_fifo.sv
module tlpmb_fifo #(
    parameter int WIDTH = 66,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CNT_W'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        head = mem_q[st_q.rptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= wdata;
    end
endmodule

// File: rtl/tlpmb_txstage.sv
module tlpmb_txstage
    import tlpmb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              q_full,
    output logic              push,
    output beat_t             beat,
    output logic              ovf
);
    typedef struct packed {
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] hi;
        logic             ovf;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        push = 1'b0;
        if (reg_wr) begin
            if (reg_addr == ADDR_W'(OFS_TX_LO)) st_d.lo = reg_wdata;
            if (reg_addr == ADDR_W'(OFS_TX_HI)) st_d.hi = reg_wdata;
            if (reg_addr == ADDR_W'(OFS_TX_CTL)) begin
                push = 1'b1;
                if (q_full) st_d.ovf = 1'b1;
            end
        end
        beat.data = {st_q.hi, st_q.lo};
        beat.sop  = reg_wdata[0];
        beat.eop  = reg_wdata[1];
        ovf       = st_q.ovf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlpmb_rxread.sv
module tlpmb_rxread
    import tlpmb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  beat_t             head,
    input  logic              q_empty,
    output logic              pop,
    output logic [REG_W-1:0]  rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic [REG_W-1:0] rdata;
        logic             rvalid;
    } rd_t;

    rd_t st_d, st_q;
    logic [REG_W-1:0] mux;

    always_comb begin
        mux = '0;
        if (reg_addr == ADDR_W'(OFS_STATUS)) begin
            mux[0] = !q_empty;
            mux[1] = !q_empty && head.eop;
        end else if (reg_addr == ADDR_W'(OFS_RX_LO)) begin
            mux = q_empty ? '0 : head.data[REG_W-1:0];
        end else if (reg_addr == ADDR_W'(OFS_RX_HI)) begin
            mux = q_empty ? '0 : head.data[2*REG_W-1:REG_W];
        end
        pop          = reg_rd && (reg_addr == ADDR_W'(OFS_RX_HI)) && !q_empty;
        st_d.rvalid  = reg_rd;
        st_d.rdata   = reg_rd ? mux : '0;
        rdata        = st_q.rdata;
        rvalid       = st_q.rvalid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlpmb_mailbox.sv
module tlpmb_mailbox
    import tlpmb_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [63:0]       tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              tx_ovf,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [63:0]       rx_data,
    input  logic              rx_sop,
    input  logic              rx_eop
);
    beat_t tx_in, tx_head, rx_in, rx_head;
    logic  tx_push, tx_full, tx_empty;
    logic  rx_pop, rx_full, rx_empty;

    tlpmb_txstage #(.ADDR_W(ADDR_W)) u_txstage (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .q_full(tx_full), .push(tx_push),
        .beat(tx_in), .ovf(tx_ovf)
    );

    tlpmb_fifo #(.WIDTH(ENTRY_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_in),
        .pop(tx_valid && tx_ready), .head(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    always_comb begin
        tx_valid   = !tx_empty;
        tx_data    = tx_head.data;
        tx_sop     = tx_head.sop;
        tx_eop     = tx_head.eop;
        rx_ready   = !rx_full;
        rx_in.data = rx_data;
        rx_in.sop  = rx_sop;
        rx_in.eop  = rx_eop;
    end

    tlpmb_fifo #(.WIDTH(ENTRY_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_valid && rx_ready), .wdata(rx_in),
        .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty)
    );

    tlpmb_rxread #(.ADDR_W(ADDR_W)) u_rxread (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .head(rx_head), .q_empty(rx_empty), .pop(rx_pop),
        .rdata(reg_rdata), .rvalid(reg_rvalid)
    );
endmodule

// File: rtl/tlpmb_checker.sv
module tlpmb_checker #(
    parameter int ADDR_W   = 8,
    parameter int RX_DEPTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              reg_rvalid,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [63:0]       tx_data,
    input logic              tx_sop,
    input logic              tx_eop,
    input logic              tx_ovf,
    input logic              rx_valid,
    input logic              rx_ready
);
    localparam int OCC_W = $clog2(RX_DEPTH + 1);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'('h10);
    localparam logic [ADDR_W-1:0] A_RX_HI  = ADDR_W'('h18);

    logic [OCC_W-1:0] occ;
    logic             took, gave;

    assign took = rx_valid && rx_ready;
    assign gave = reg_rd && (reg_addr == A_RX_HI) && (occ != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else if (took && !gave) occ <= occ + 1'b1;
        else if (gave && !took) occ <= occ - 1'b1;
    end

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);

    assert_rx_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(RX_DEPTH)) |-> !rx_ready);

    assert_rx_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < OCC_W'(RX_DEPTH)) |-> rx_ready);

    assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    assert_no_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    assert_status_res_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STATUS) |=> (reg_rdata[31:2] == '0));
endmodule

bind tlpmb_mailbox tlpmb_checker #(.ADDR_W(ADDR_W), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_ovf(tx_ovf), .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/tlpmb_mailbox_bench.sv
`timescale 1ns/1ps
module tlpmb_mailbox_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        tx_valid, tx_ready = 1'b0;
    logic [63:0] tx_data;
    logic        tx_sop, tx_eop, tx_ovf;
    logic        rx_valid = 1'b0, rx_ready;
    logic [63:0] rx_data = '0;
    logic        rx_sop = 1'b0, rx_eop = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tlpmb_mailbox u_tlpmb_mailbox (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_ovf(tx_ovf),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_sop(rx_sop), .rx_eop(rx_eop)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
        check("R11 rvalid", {63'd0, reg_rvalid}, 64'd1);
    endtask

    task automatic rx_offer(input logic [63:0] d, input logic s, input logic e);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_sop = s; rx_eop = e;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx_take(input string req, input logic [63:0] d, input logic s, input logic e);
        @(negedge clk);
        check(req, {tx_valid, tx_sop, tx_eop, tx_data[60:0]}, {1'b1, s, e, d[60:0]});
        check(req, tx_data, d);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        check("R1 tx_valid", {63'd0, tx_valid}, 64'd0);
        check("R1 tx_ovf", {63'd0, tx_ovf}, 64'd0);
        check("R1 rx_ready", {63'd0, rx_ready}, 64'd1);
        host_rd(8'h10, d);
        check("R1 status", {32'd0, d}, 64'd0);
        @(negedge clk);
        check("R11 rvalid drops", {63'd0, reg_rvalid}, 64'd0);
    endtask

    task automatic t_tx_single();
        host_wr(8'h00, 32'h1111_2222);
        host_wr(8'h04, 32'hAAAA_BBBB);
        host_wr(8'h08, 32'h0000_0003);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R4 hold", {tx_valid, tx_sop, tx_eop, 61'd0}, {3'b111, 61'd0});
            check("R4 hold data", tx_data, 64'hAAAA_BBBB_1111_2222);
        end
        tx_take("R2 single beat", 64'hAAAA_BBBB_1111_2222, 1'b1, 1'b1);
        @(negedge clk);
        check("R4 gone", {63'd0, tx_valid}, 64'd0);
    endtask

    task automatic t_tx_packet();
        host_wr(8'h00, 32'h0000_0010);
        host_wr(8'h04, 32'h5555_0000);
        host_wr(8'h08, 32'h1);
        host_wr(8'h00, 32'h0000_0011);
        host_wr(8'h08, 32'h0);
        host_wr(8'h00, 32'h0000_0012);
        host_wr(8'h08, 32'h2);
        tx_take("R2 first", 64'h5555_0000_0000_0010, 1'b1, 1'b0);
        tx_take("R5 middle keeps hi", 64'h5555_0000_0000_0011, 1'b0, 1'b0);
        tx_take("R5 last keeps hi", 64'h5555_0000_0000_0012, 1'b0, 1'b1);
    endtask

    task automatic t_tx_overflow();
        host_wr(8'h04, 32'hC0DE_0000);
        for (int i = 0; i < 8; i++) begin
            host_wr(8'h00, 32'(i));
            host_wr(8'h08, 32'h0);
        end
        check("R3 no ovf at 8", {63'd0, tx_ovf}, 64'd0);
        host_wr(8'h00, 32'h99);
        host_wr(8'h08, 32'h3);
        check("R3 ovf set", {63'd0, tx_ovf}, 64'd1);
        for (int i = 0; i < 8; i++) begin
            tx_take("R3 drain", {32'hC0DE_0000, 32'(i)}, 1'b0, 1'b0);
        end
        @(negedge clk);
        check("R3 ninth dropped", {63'd0, tx_valid}, 64'd0);
        check("R3 ovf sticky", {63'd0, tx_ovf}, 64'd1);
    endtask

    task automatic t_rx_basic();
        logic [31:0] d;
        rx_offer(64'h0101_0202_0303_0404, 1'b1, 1'b0);
        rx_offer(64'h0505_0606_0707_0808, 1'b0, 1'b1);
        host_rd(8'h10, d);
        check("R6 status mid", {32'd0, d}, 64'd1);
        host_rd(8'h14, d);
        check("R7 lo", {32'd0, d}, 64'h0303_0404);
        host_rd(8'h14, d);
        check("R7 lo no pop", {32'd0, d}, 64'h0303_0404);
        host_rd(8'h18, d);
        check("R7 hi", {32'd0, d}, 64'h0101_0202);
        host_rd(8'h10, d);
        check("R6 status eop", {32'd0, d}, 64'd3);
        host_rd(8'h14, d);
        check("R7 next lo", {32'd0, d}, 64'h0707_0808);
        host_rd(8'h18, d);
        check("R7 next hi", {32'd0, d}, 64'h0505_0606);
        host_rd(8'h10, d);
        check("R6 status empty", {32'd0, d}, 64'd0);
    endtask

    task automatic t_rx_full();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            rx_offer({32'(i + 100), 32'(i)}, i == 0, i == 7);
        end
        @(negedge clk);
        check("R8 ready low when full", {63'd0, rx_ready}, 64'd0);
        rx_offer(64'hDEAD_DEAD_DEAD_DEAD, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            host_rd(8'h14, d);
            check("R8 order lo", {32'd0, d}, {32'd0, 32'(i)});
            host_rd(8'h18, d);
            check("R8 order hi", {32'd0, d}, {32'd0, 32'(i + 100)});
        end
        host_rd(8'h14, d);
        check("R9 empty lo", {32'd0, d}, 64'd0);
        host_rd(8'h18, d);
        check("R9 empty hi", {32'd0, d}, 64'd0);
        host_rd(8'h10, d);
        check("R9 status after", {32'd0, d}, 64'd0);
        @(negedge clk);
        check("R8 ready back", {63'd0, rx_ready}, 64'd1);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        logic [7:0] offs [5] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h1C};
        host_wr(8'h00, 32'hFFFF_FFFF);
        host_wr(8'h04, 32'hFFFF_FFFF);
        foreach (offs[i]) begin
            host_rd(offs[i], d);
            check("R10 reads zero", {32'd0, d}, 64'd0);
        end
        rx_offer(64'h1234_5678_9ABC_DEF0, 1'b1, 1'b1);
        host_wr(8'h10, 32'hFFFF_FFFF);
        host_wr(8'h14, 32'hFFFF_FFFF);
        host_wr(8'h18, 32'hFFFF_FFFF);
        host_rd(8'h10, d);
        check("R10 status untouched", {32'd0, d}, 64'd3);
        host_rd(8'h14, d);
        check("R10 lo untouched", {32'd0, d}, 64'h9ABC_DEF0);
        host_rd(8'h18, d);
        check("R10 hi untouched", {32'd0, d}, 64'h1234_5678);
        @(negedge clk);
        check("R10 tx untouched", {63'd0, tx_valid}, 64'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_single();
        t_tx_packet();
        t_tx_overflow();
        t_rx_basic();
        t_rx_full();
        t_reserved();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule